// File: doc/BRIEF.md
# Video Crosspoint Programming Interface

This block is the digital front end of an eight-output, eight-input video routing matrix. Software programs it in one of two ways. In serial mode, a bitstream is clocked in one bit per write strobe, and a serial output lets several parts be chained. In parallel mode, 4-bit words are written to an addressed output. A strapped input chooses the mode. Writes land in a master register. A latch step then moves the master contents into a slave register, and the slave register drives the matrix.

The latch step has three triggers. It can fire on a rising edge of the latch pin. It can run transparently while the latch pin is low. It can also be issued as a software latch command. A few parallel command codes act at once, with no latch. Each output has its own 4-bit code. The block decodes each code into a 3-bit input select and an output enable. When an output's code changes, its enable is held low for one clock before the new selection is enabled.

The write strobe and the latch pin are asynchronous. Both pass through two-flop synchronisers and edge detectors into the system clock.

Top module: `xbar_ctrl`

## Requirements
- R1: After reset, every output enable is 0, every select is 0, and `ser_out` is 1, because every entry holds the disable code 1000.
- R2: A parallel write with code 0000–0111 to address `addr` routes that input number to output `addr`. After the slave update, `sel[3*addr+:3]` equals the code and `en[addr]` is 1.
- R3: Parallel code 1000 disables the addressed output, so its enable is 0 after the slave update.
- R4: Parallel codes 1001, 1010 and 1110 change neither the master register nor any output.
- R5: Code 1011 clears every enable at once, and code 1100 restores them. Neither waits for a latch, and both work in either latch mode.
- R6: Code 1101 sets every master and slave entry to 1000 at once, so all enables go to 0.
- R7: Code 1111 copies the master register into the slave register, whatever the state of the latch pin.
- R8: With `edge_mode`=1, the slave register loads only on a rising edge of `latch`.
- R9: With `edge_mode`=0, the slave register follows the master register while `latch` is 0 and holds while `latch` is 1.
- R10: A write strobe has no effect unless `ce_n`=0 and `ce`=1.
- R11: With `ser_par`=1, each write strobe shifts `din[0]` into bit 0 of the 32-bit master chain. Output 7's entry sits at the top of the chain. `ser_out` is the top bit of the chain, and `din[3:1]` are ignored.
- R12: Whenever an output's select changes, its enable is 0 in that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_par | input | 1 | Strap: 1 selects serial mode, 0 selects parallel mode |
| edge_mode | input | 1 | Strap: 1 selects edge latching, 0 selects level latching |
| wr | input | 1 | Asynchronous write strobe, acts on its rising edge |
| latch | input | 1 | Asynchronous latch control |
| ce_n | input | 1 | Active-low chip enable |
| ce | input | 1 | Active-high chip enable |
| addr | input | 3 | Output address for parallel writes |
| din | input | 4 | Parallel code; bit 0 is the serial input |
| ser_out | output | 1 | Top bit of the master chain, for daisy-chaining |
| sel | output | 24 | Input select for each output, 3 bits per output |
| en | output | 8 | Enable for each output |

## Verification
The assertions assume that `ce_n`, `ce`, `addr` and `din` hold steady from before a write strobe rises until well after the synchronised edge has been used. Only `wr` and `latch` are treated as asynchronous. The bench sets the data and enables in the same cycle as it raises `wr`. It holds them for eight clocks and changes them only after `wr` has fallen. The strapped inputs change only while the strobes are idle.

// File: rtl/xbar_ctrl.sv
module xbar_ctrl #(
  parameter int N_OUT  = 8,
  parameter int CODE_W = 4,
  parameter int ADDR_W = $clog2(N_OUT)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ser_par,
  input  logic                        edge_mode,
  input  logic                        wr,
  input  logic                        latch,
  input  logic                        ce_n,
  input  logic                        ce,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [CODE_W-1:0]           din,
  output logic                        ser_out,
  output logic [N_OUT*(CODE_W-1)-1:0] sel,
  output logic [N_OUT-1:0]            en
);
  localparam int SEL_W = CODE_W - 1;
  localparam int MW    = N_OUT * CODE_W;
  localparam logic [CODE_W-1:0] C_OFF  = {1'b1, {SEL_W{1'b0}}};
  localparam logic [CODE_W-1:0] C_DALL = CODE_W'(11);
  localparam logic [CODE_W-1:0] C_EALL = CODE_W'(12);
  localparam logic [CODE_W-1:0] C_CLR  = CODE_W'(13);
  localparam logic [CODE_W-1:0] C_SOFT = CODE_W'(15);
  localparam logic [MW-1:0]     ALL_OFF = {N_OUT{C_OFF}};

  logic [2:0]    wr_sh, la_sh;
  logic [MW-1:0] master_v, slave_v, slave_q;
  logic          glob_en;

  wire wr_rise = wr_sh[1] & ~wr_sh[2];
  wire la_rise = la_sh[1] & ~la_sh[2];
  wire wr_go   = wr_rise & ~ce_n & ce;
  wire is_par  = wr_go & ~ser_par;
  wire par_ld  = is_par & (din <= C_OFF);
  wire do_clr  = is_par & (din == C_CLR);
  wire do_soft = is_par & (din == C_SOFT);
  wire do_xfer = (edge_mode & la_rise) | (~edge_mode & ~la_sh[1]) | do_soft;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_sh    <= '0;
      la_sh    <= '0;
      master_v <= ALL_OFF;
      slave_v  <= ALL_OFF;
      slave_q  <= ALL_OFF;
      glob_en  <= 1'b1;
    end else begin
      wr_sh   <= {wr_sh[1:0], wr};
      la_sh   <= {la_sh[1:0], latch};
      slave_q <= slave_v;
      if (wr_go && ser_par)
        master_v <= {master_v[MW-2:0], din[0]};
      else if (par_ld)
        master_v[addr*CODE_W +: CODE_W] <= din;
      else if (do_clr)
        master_v <= ALL_OFF;
      if (do_clr)
        slave_v <= ALL_OFF;
      else if (do_xfer)
        slave_v <= master_v;
      if (is_par && din == C_DALL)
        glob_en <= 1'b0;
      else if (is_par && din == C_EALL)
        glob_en <= 1'b1;
    end
  end

  assign ser_out = master_v[MW-1];

  for (genvar i = 0; i < N_OUT; i++) begin : g_out
    wire [CODE_W-1:0] cur = slave_v[i*CODE_W +: CODE_W];
    wire [CODE_W-1:0] old = slave_q[i*CODE_W +: CODE_W];
    assign sel[i*SEL_W +: SEL_W] = cur[SEL_W-1:0];
    assign en[i] = glob_en & ~cur[SEL_W] & (cur == old);
  end
endmodule

// File: rtl/xbar_ctrl_chk.sv
module xbar_ctrl_chk #(
  parameter int N_OUT  = 8,
  parameter int CODE_W = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        ser_par,
  input logic                        ce_n,
  input logic                        ce,
  input logic [CODE_W-1:0]           din,
  input logic                        ser_out,
  input logic [N_OUT*(CODE_W-1)-1:0] sel,
  input logic [N_OUT-1:0]            en,
  input logic                        wr_go,
  input logic [N_OUT*CODE_W-1:0]     master_v
);
  localparam int SEL_W = CODE_W - 1;
  localparam int MW    = N_OUT * CODE_W;
  localparam logic [MW-1:0] ALL_OFF = {N_OUT{1'b1, {SEL_W{1'b0}}}};

  for (genvar i = 0; i < N_OUT; i++) begin : g_bbm
    AST_BREAK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (sel[i*SEL_W +: SEL_W] != $past(sel[i*SEL_W +: SEL_W])) |-> !en[i]); // R12
  end

  AST_SER_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_par && wr_go) |=> (ser_out == $past(master_v[MW-2]))); // R11

  AST_CE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || !ce) |=> (master_v == $past(master_v))); // R10

  AST_RESERVED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && !ser_par && (din == 4'b1001 || din == 4'b1010 || din == 4'b1110))
    |=> (master_v == $past(master_v))); // R4

  AST_DISABLE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && !ser_par && din == 4'b1011) |=> (en == '0)); // R5

  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && !ser_par && din == 4'b1101) |=> (en == '0 && master_v == ALL_OFF)); // R6
endmodule

bind xbar_ctrl xbar_ctrl_chk #(.N_OUT(N_OUT), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ser_par(ser_par), .ce_n(ce_n), .ce(ce),
  .din(din), .ser_out(ser_out), .sel(sel), .en(en),
  .wr_go(wr_go), .master_v(master_v)
);

// File: tb/tb_xbar_ctrl.sv
module tb_xbar_ctrl;
  logic clk = 0, rst_n = 0;
  logic ser_par = 0, edge_mode = 1, wr = 0, latch = 0, ce_n = 0, ce = 1;
  logic [2:0] addr = 0;
  logic [3:0] din = 0;
  logic ser_out;
  logic [23:0] sel;
  logic [7:0] en;
  int n_chk = 0, n_fail = 0, bbm_viol = 0;
  logic [23:0] sel_prev = 0;

  always #2 clk = ~clk;

  xbar_ctrl dut (.clk(clk), .rst_n(rst_n), .ser_par(ser_par), .edge_mode(edge_mode),
    .wr(wr), .latch(latch), .ce_n(ce_n), .ce(ce), .addr(addr), .din(din),
    .ser_out(ser_out), .sel(sel), .en(en));

  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < 8; i++)
        if (sel[i*3 +: 3] != sel_prev[i*3 +: 3] && en[i]) bbm_viol++;
    end
    sel_prev = sel;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_word(input logic [2:0] a, input logic [3:0] d);
    @(negedge clk);
    addr = a; din = d; wr = 1;
    idle(4);
    wr = 0;
    idle(4);
  endtask

  task automatic pulse_latch();
    @(negedge clk); latch = 1; idle(5); latch = 0; idle(5);
  endtask

  task automatic t_reset();
    chk("R1 en", en, 8'h00);
    chk("R1 sel", sel, 24'h0);
    chk("R1 ser_out", ser_out, 1);
  endtask

  task automatic t_edge();
    wr_word(0, 4'd3); wr_word(5, 4'd7);
    chk("R8 no latch yet", en, 8'h00);
    pulse_latch();
    chk("R2 sel0", sel[2:0], 3);
    chk("R2 sel5", sel[17:15], 7);
    chk("R2 en", en, 8'b0010_0001);
  endtask

  task automatic t_off_code();
    wr_word(5, 4'b1000); wr_word(0, 4'd6);
    pulse_latch();
    chk("R3 en", en, 8'b0000_0001);
    chk("R2 sel0 new", sel[2:0], 6);
  endtask

  task automatic t_ignored();
    wr_word(0, 4'b1001); wr_word(0, 4'b1010); wr_word(0, 4'b1110);
    pulse_latch();
    chk("R4 sel0", sel[2:0], 6);
    chk("R4 en", en, 8'b0000_0001);
  endtask

  task automatic t_level();
    edge_mode = 0; latch = 1; idle(4);
    wr_word(1, 4'd2);
    chk("R9 hold", en, 8'b0000_0001);
    latch = 0; idle(6);
    chk("R9 open en", en, 8'b0000_0011);
    chk("R9 open sel1", sel[5:3], 2);
    wr_word(2, 4'd4); idle(4);
    chk("R9 transparent", en, 8'b0000_0111);
    latch = 1; idle(4);
  endtask

  task automatic t_soft();
    wr_word(3, 4'd5);
    chk("R7 before", en, 8'b0000_0111);
    wr_word(0, 4'b1111);
    chk("R7 after en", en, 8'b0000_1111);
    chk("R7 after sel3", sel[11:9], 5);
  endtask

  task automatic t_global();
    wr_word(0, 4'b1011);
    chk("R5 off", en, 8'h00);
    wr_word(0, 4'b1100);
    chk("R5 on", en, 8'b0000_1111);
  endtask

  task automatic t_ce();
    ce_n = 1; wr_word(4, 4'd1); wr_word(0, 4'b1111);
    ce_n = 0; ce = 0; wr_word(4, 4'd1); wr_word(0, 4'b1111);
    ce = 1; idle(2);
    chk("R10 en", en, 8'b0000_1111);
  endtask

  task automatic t_clear();
    wr_word(0, 4'b1101);
    chk("R6 en", en, 8'h00);
    chk("R6 ser_out", ser_out, 1);
    wr_word(0, 4'b1111);
    chk("R6 after soft", en, 8'h00);
  endtask

  task automatic t_serial();
    logic [31:0] word;
    ser_par = 1; edge_mode = 1; latch = 0; idle(4);
    for (int i = 0; i < 7; i++) word[i*4 +: 4] = 4'(i);
    word[31:28] = 4'b1000;
    for (int b = 31; b >= 0; b--) wr_word(3'd0, {3'b111, word[b]});
    chk("R11 ser_out", ser_out, 1);
    chk("R11 en before latch", en, 8'h00);
    pulse_latch();
    chk("R11 en", en, 8'h7F);
    chk("R11 sel", sel, {3'd0, 3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0});
    wr_word(3'd0, 4'b1110);
    chk("R11 shifted", ser_out, 0);
  endtask

  initial begin
    idle(3); rst_n = 1; idle(4);
    t_reset(); t_edge(); t_off_code(); t_ignored(); t_level();
    t_soft(); t_global(); t_ce(); t_clear(); t_serial();
    chk("R12 no enable during select change", bbm_viol, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule